// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a segmented virtual address into a physical address. A request carries a segment number and an offset. The segment number picks one row of a small table, and each row holds a base, a limit and a valid flag. If the row is valid and the offset lies strictly below its limit, the block returns base plus offset. In every other case it raises a protection fault and produces no address.

The table is loaded through a simple write port that supplies a row index, a base and a limit. That write also marks the row valid. A translation result appears on registered outputs one clock after the request. The address-valid and fault flags are never high together, and both are low in any cycle that follows a clock without a request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table row is invalid, all outputs are low, and a translation through any row faults until that row is written.
- R2: For a request whose row is valid and whose offset is strictly less than the row's limit, the cycle after the request shows `xl_ok`=1, `xl_fault`=0 and `xl_paddr` = base + offset, wrapping modulo 2^ADDR_W.
- R3: For a request to a valid row whose offset is equal to or greater than the row's limit, the next cycle shows `xl_fault`=1 and `xl_ok`=0. This includes a limit of zero.
- R4: A request through a row that is not valid gives `xl_fault`=1 and `xl_ok`=0 on the next cycle, whatever the offset.
- R5: `xl_ok` and `xl_fault` are never high together. Exactly one of them is high in the cycle after a request, and both are low in the cycle after a clock with no request.
- R6: When a write and a request use the same row on the same clock, the request is translated with that row's previous contents. The new contents apply from the next request onward.
- R7: A write replaces both the base and the limit of its own row and leaves every other row unchanged.
- R8: `xl_paddr` is zero whenever `xl_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tw_en | input | 1 | Table write strobe |
| tw_row | input | $clog2(SEG_COUNT) | Row to write |
| tw_base | input | ADDR_W | Base to store |
| tw_limit | input | ADDR_W | Limit to store |
| xl_req | input | 1 | Translation request |
| xl_seg | input | $clog2(SEG_COUNT) | Segment number (table row) |
| xl_off | input | ADDR_W | Offset within the segment |
| xl_ok | output | 1 | Physical address valid |
| xl_fault | output | 1 | Protection fault |
| xl_paddr | output | ADDR_W | Translated physical address |

## Verification
Every result is due exactly one rising edge after its request: writes take effect at that edge, and outputs reflect the table contents from before it. The bench drives inputs on the falling edge. It updates a behavioural model of the table as of the coming rising edge and computes the expected outputs from the table contents held before that edge. It compares all three outputs one time unit after the rising edge, on every clock including idle and reset cycles. This lock-step comparison is what exercises the write-versus-request ordering on the same row.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 32,
  localparam int ROW_W    = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_en,
  input  logic [ROW_W-1:0]  tw_row,
  input  logic [ADDR_W-1:0] tw_base,
  input  logic [ADDR_W-1:0] tw_limit,
  input  logic              xl_req,
  input  logic [ROW_W-1:0]  xl_seg,
  input  logic [ADDR_W-1:0] xl_off,
  output logic              xl_ok,
  output logic              xl_fault,
  output logic [ADDR_W-1:0] xl_paddr
);

  logic [ADDR_W-1:0]    base_q  [SEG_COUNT];
  logic [ADDR_W-1:0]    limit_q [SEG_COUNT];
  logic [SEG_COUNT-1:0] live_q;

  logic                 row_ok;
  logic                 in_bounds;
  logic                 hit;
  logic [ADDR_W-1:0]    sum;

  generate
    if (SEG_COUNT == (1 << ROW_W)) begin : g_full
      assign row_ok = 1'b1;
    end else begin : g_part
      assign row_ok = (32'(xl_seg) < SEG_COUNT);
    end
  endgenerate

  assign in_bounds = xl_off < limit_q[xl_seg];
  assign hit       = row_ok && live_q[xl_seg] && in_bounds;
  assign sum       = base_q[xl_seg] + xl_off;

  always_ff @(posedge clk) begin
    if (tw_en) begin
      base_q[tw_row]  <= tw_base;
      limit_q[tw_row] <= tw_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (tw_en) begin
      live_q[tw_row] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_ok    <= 1'b0;
      xl_fault <= 1'b0;
      xl_paddr <= '0;
    end else begin
      xl_ok    <= xl_req && hit;
      xl_fault <= xl_req && !hit;
      xl_paddr <= (xl_req && hit) ? sum : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xl_req,
  input logic              xl_ok,
  input logic              xl_fault,
  input logic [ADDR_W-1:0] xl_paddr
);

  AST_ONE_HOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_ok && xl_fault)); // R5

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xl_ok ^ xl_fault)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> (!xl_ok && !xl_fault)); // R5

  AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_ok |-> (xl_paddr == '0)); // R8

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xl_req   (xl_req),
  .xl_ok    (xl_ok),
  .xl_fault (xl_fault),
  .xl_paddr (xl_paddr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int RW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tw_en;
  logic [RW-1:0] tw_row;
  logic [AW-1:0] tw_base, tw_limit;
  logic          xl_req;
  logic [RW-1:0] xl_seg;
  logic [AW-1:0] xl_off;
  logic          xl_ok, xl_fault;
  logic [AW-1:0] xl_paddr;

  always #5 clk = ~clk;

  seg_xlate #(.SEG_COUNT(N), .ADDR_W(AW)) dut_i (.*);

  int total = 0;
  int bad   = 0;

  logic [AW-1:0] m_base [N];
  logic [AW-1:0] m_lim  [N];
  bit            m_live [N];

  task automatic check(string tag, bit e_ok, bit e_f, logic [AW-1:0] e_a);
    total++;
    if (xl_ok !== e_ok || xl_fault !== e_f || xl_paddr !== e_a) begin
      bad++;
      $display("FAIL %s: got ok=%0b fault=%0b addr=%h, want ok=%0b fault=%0b addr=%h",
               tag, xl_ok, xl_fault, xl_paddr, e_ok, e_f, e_a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tw_en = 1'b0; xl_req = 1'b0;
    tw_row = '0; tw_base = '0; tw_limit = '0; xl_seg = '0; xl_off = '0;
    for (int i = 0; i < N; i++) m_live[i] = 1'b0;
    @(posedge clk); #1;
    check("R1 reset", 1'b0, 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One clock: drive at falling edge, model, compare after the rising edge.
  task automatic step(bit we, int wr, logic [AW-1:0] wb, logic [AW-1:0] wl,
                      bit rq, int sg, logic [AW-1:0] off, string tag);
    bit e_ok, e_f;
    logic [AW-1:0] e_a;
    string t;
    @(negedge clk);
    tw_en = we; tw_row = RW'(wr); tw_base = wb; tw_limit = wl;
    xl_req = rq; xl_seg = RW'(sg); xl_off = off;
    e_ok = 1'b0; e_f = 1'b0; e_a = '0; t = tag;
    if (rq) begin
      if (!m_live[sg]) begin
        e_f = 1'b1; if (t == "") t = "R4";
      end else if (off >= m_lim[sg]) begin
        e_f = 1'b1; if (t == "") t = "R3";
      end else begin
        e_ok = 1'b1; e_a = m_base[sg] + off; if (t == "") t = "R2";
      end
    end else if (t == "") t = "R5";
    if (we) begin
      m_base[wr] = wb; m_lim[wr] = wl; m_live[wr] = 1'b1;
    end
    @(posedge clk); #1;
    check(t, e_ok, e_f, e_a);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    step(0, 0, 0, 0, 1, 3, 32'h0, "R1 invalid after reset");
    step(0, 0, 0, 0, 0, 0, 0, "R5 idle");

    for (int i = 0; i < N; i++)
      step(1, i, 32'h1000_0000 * i + 32'h100, 32'h40 + 32'h10 * i, 0, 0, 0, "R5 load");

    step(0, 0, 0, 0, 1, 1, 32'h10, "R2 inside");
    step(0, 0, 0, 0, 1, 1, 32'h4F, "R2 last byte");
    step(0, 0, 0, 0, 1, 1, 32'h50, "R3 at limit");
    step(0, 0, 0, 0, 1, 5, 32'hFFFF_FFFF, "R3 far beyond");
    step(0, 0, 0, 0, 1, 7, 32'h0, "R2 offset zero");

    step(1, 6, 32'h1234_0000, 32'h0, 0, 0, 0, "R5 load zero limit");
    step(0, 0, 0, 0, 1, 6, 32'h0, "R3 zero limit");

    step(1, 4, 32'hFFFF_FFF0, 32'h100, 0, 0, 0, "R5 load wrap");
    step(0, 0, 0, 0, 1, 4, 32'h20, "R2 wrap");

    step(1, 2, 32'hAAAA_0000, 32'h8, 1, 2, 32'h30, "R6 same row old contents");
    step(0, 0, 0, 0, 1, 2, 32'h30, "R6 new limit applies");
    step(0, 0, 0, 0, 1, 2, 32'h7, "R7 new base");
    step(0, 0, 0, 0, 1, 3, 32'h30, "R7 neighbour kept");
    step(1, 3, 32'h0, 32'h1, 1, 5, 32'h3, "R7 other row during write");

    for (int k = 0; k < 400; k++)
      step($urandom_range(0, 3) == 0, $urandom_range(0, N - 1), $urandom,
           $urandom_range(0, 300), $urandom_range(0, 2) != 0,
           $urandom_range(0, N - 1), $urandom_range(0, 320), "");

    do_reset();
    step(0, 0, 0, 0, 1, 1, 32'h0, "R1 cleared by reset");
    step(1, 1, 32'h55, 32'h2, 0, 0, 0, "R5 idle after write");
    step(0, 0, 0, 0, 1, 1, 32'h1, "R2 after reset reload");
    step(0, 0, 0, 0, 1, 0, 32'h1, "R4 unwritten row");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule